// File: doc/BRIEF.md
# Clock Control Register with Lock-Change Interrupt

This block is the 8-bit control and status register of a clock generator, seen by the CPU through a simple read/write port. It decodes its own bus address. The register holds four working bits: an interrupt enable, a sticky lock-change flag, a PLL power control and a base-clock select. The PLL itself, the clock switching logic and the neighbouring bandwidth register are outside the block. They appear only as the `lock_in` and `auto_bw` inputs and the `pll_on` and `clk_sel` outputs.

The asynchronous lock indication passes through a two-stage synchroniser. A two-state tracker, with states `LK_LOW` and `LK_HIGH`, follows the synchronised level. The tracker takes the transitions `LK_LOW -> LK_HIGH` on a rising lock and `LK_HIGH -> LK_LOW` on a falling lock, and either transition emits a one-cycle toggle event. The flag is a second two-state machine, with states `FL_CLEAR` and `FL_PENDING`. It moves `FL_CLEAR -> FL_PENDING` on a toggle event, and `FL_PENDING -> FL_CLEAR` on a register read when no toggle arrives in the same cycle. An interrupt request is raised while the flag and the enable are both visible. Both bits are masked whenever the automatic-bandwidth mode from the neighbouring register is off.

Top module: `clkctl_reg`

## Requirements
- R1: The register answers only at bus address 0x1C. A read of any other address returns 0x00, and a write to any other address changes nothing.
- R2: After reset the register reads 0x2F when `auto_bw` is 1, with `pll_on` at 1, `clk_sel` at 0 and `irq` at 0.
- R3: Read data layout: bit 7 is the interrupt enable, bit 6 the lock-change flag, bit 5 the PLL on bit and bit 4 the clock select. Bits 3..0 always read as 1.
- R4: A write to the register loads bit 5 into `pll_on` and bit 4 into `clk_sel`, and both take effect after the next clock edge.
- R5: Bit 7 of a write loads the interrupt enable only while `auto_bw` is 1. While `auto_bw` is 0 the enable reads as 0 and writes leave its stored value unchanged, so the stored value reappears when `auto_bw` returns to 1.
- R6: The flag sets on every rising or falling change of `lock_in`. It is visible after the third rising clock edge that follows the change: two synchroniser stages plus one edge-detect stage.
- R7: Writes to bit 6 and to bits 3..0 have no effect.
- R8: Any read of the register, including a read combined with a write in the same cycle, returns the current flag value and clears the flag after that cycle.
- R9: If a lock toggle event and a read fall in the same cycle, the flag is set after that cycle.
- R10: While `auto_bw` is 0 the flag reads as 0.
- R11: `irq` is 1 exactly when the flag and the enable are both 1 and `auto_bw` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 (ADDR_W) | CPU bus address |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational while a read hits the register, else 0 |
| lock_in | input | 1 | Asynchronous PLL lock indication |
| auto_bw | input | 1 | Automatic-bandwidth mode from the neighbouring register |
| pll_on | output | 1 | PLL power control |
| clk_sel | output | 1 | Base clock select |
| irq | output | 1 | Lock-change interrupt request |

## Verification
A wrong flag state shows at `irq` in the same cycle, provided the enable is set. It also shows in bit 6 of the very next read, so every read is scored against a queue of expected bytes. A fault in the lock tracker or the synchroniser moves or loses a toggle event. That shows as a flag rising one cycle early or late, so `irq` is sampled both two and three edges after each lock change. A mis-ordered set/clear decision appears only in the read that follows a coincident toggle and read. The bench therefore aims a read at exactly that cycle, with the flag already set beforehand.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    localparam int DATA_W = 8;

    // Bit positions inside the register byte
    localparam int IE_BIT   = 7;
    localparam int FLAG_BIT = 6;
    localparam int PLL_BIT  = 5;
    localparam int SEL_BIT  = 4;
    localparam int RSV_W    = 4;

    localparam logic [RSV_W-1:0] RSV_VALUE = '1;

    typedef enum logic {
        LK_LOW  = 1'b0,
        LK_HIGH = 1'b1
    } lock_st_t;

    typedef enum logic {
        FL_CLEAR   = 1'b0,
        FL_PENDING = 1'b1
    } flag_st_t;

endpackage

// File: rtl/clkctl_lock_track.sv
module clkctl_lock_track
    import clkctl_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lock_async,
    output logic toggle
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   lock_sync;
    lock_st_t               state_q;
    lock_st_t               state_d;

    generate
        if (SYNC_STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= lock_async;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) sync_q <= '0;
                else        sync_q <= {sync_q[SYNC_STAGES-2:0], lock_async};
            end
        end
    endgenerate

    assign lock_sync = sync_q[SYNC_STAGES-1];

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= LK_LOW;
        else        state_q <= state_d;
    end

    // Transitions and outputs
    always_comb begin
        state_d = state_q;
        toggle  = 1'b0;
        unique case (state_q)
            LK_LOW: begin
                if (lock_sync) begin
                    state_d = LK_HIGH;
                    toggle  = 1'b1;
                end
            end
            LK_HIGH: begin
                if (!lock_sync) begin
                    state_d = LK_LOW;
                    toggle  = 1'b1;
                end
            end
        endcase
    end

    // R6: an event is followed by the tracker agreeing with the synchronised level
    a_r6_tracker_follows: assert property (@(posedge clk) disable iff (!rst_n)
        toggle |=> (state_q == LK_HIGH) == $past(lock_sync));

endmodule

// File: rtl/clkctl_flag.sv
module clkctl_flag
    import clkctl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    flag_st_t state_q;
    flag_st_t state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_CLEAR;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FL_CLEAR:   if (set_evt)             state_d = FL_PENDING;
            FL_PENDING: if (clr_evt && !set_evt) state_d = FL_CLEAR;
        endcase
    end

    always_comb begin
        unique case (state_q)
            FL_CLEAR:   flag = 1'b0;
            FL_PENDING: flag = 1'b1;
        endcase
    end

    // R6 / R9: a toggle always leaves the flag set, even when a read clears in the same cycle
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R8: a read without a coinciding toggle clears the flag
    a_r8_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);

    // R7: nothing but a toggle raises the flag
    a_r7_only_toggle_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag && !set_evt) |=> !flag);

endmodule

// File: rtl/clkctl_ctrl.sv
module clkctl_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic auto_bw,
    input  logic wr_ie,
    input  logic wr_pll,
    input  logic wr_sel,
    output logic ie,
    output logic pll_on,
    output logic clk_sel
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ie      <= 1'b0;
            pll_on  <= 1'b1;
            clk_sel <= 1'b0;
        end else if (wr_hit) begin
            if (auto_bw) ie <= wr_ie;
            pll_on  <= wr_pll;
            clk_sel <= wr_sel;
        end
    end

    // R5: enable is frozen while automatic-bandwidth mode is off
    a_r5_ie_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_hit && !auto_bw) |=> $stable(ie));

    // R4: a write lands in the control outputs on the next edge
    a_r4_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit |=> (pll_on == $past(wr_pll)) && (clk_sel == $past(wr_sel)));

    // R1: without an addressed write the control outputs hold
    a_r1_no_stray_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_hit |=> $stable(pll_on) && $stable(clk_sel) && $stable(ie));

endmodule

// File: rtl/clkctl_reg.sv
module clkctl_reg
    import clkctl_pkg::*;
#(
    parameter int                ADDR_W      = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR    = 8'h1C,
    parameter int                SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              lock_in,
    input  logic              auto_bw,
    output logic              pll_on,
    output logic              clk_sel,
    output logic              irq
);

    logic addr_hit;
    logic rd_hit;
    logic wr_hit;
    logic toggle;
    logic flag_raw;
    logic ie_raw;
    logic ie_vis;
    logic flag_vis;
    logic unused_wdata_bits;

    assign addr_hit = (bus_addr == REG_ADDR);
    assign rd_hit   = bus_rd && addr_hit;
    assign wr_hit   = bus_wr && addr_hit;

    assign unused_wdata_bits = ^{bus_wdata[FLAG_BIT], bus_wdata[RSV_W-1:0]};

    clkctl_lock_track #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .lock_async(lock_in),
        .toggle    (toggle)
    );

    clkctl_flag u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_evt(toggle),
        .clr_evt(rd_hit),
        .flag   (flag_raw)
    );

    clkctl_ctrl u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_hit (wr_hit),
        .auto_bw(auto_bw),
        .wr_ie  (bus_wdata[IE_BIT]),
        .wr_pll (bus_wdata[PLL_BIT]),
        .wr_sel (bus_wdata[SEL_BIT]),
        .ie     (ie_raw),
        .pll_on (pll_on),
        .clk_sel(clk_sel)
    );

    assign ie_vis   = ie_raw   && auto_bw;
    assign flag_vis = flag_raw && auto_bw;
    assign irq      = ie_vis && flag_vis;

    always_comb begin
        bus_rdata = '0;
        if (rd_hit) begin
            bus_rdata[IE_BIT]      = ie_vis;
            bus_rdata[FLAG_BIT]    = flag_vis;
            bus_rdata[PLL_BIT]     = pll_on;
            bus_rdata[SEL_BIT]     = clk_sel;
            bus_rdata[RSV_W-1:0]   = RSV_VALUE;
        end
    end

    // R11: no request while automatic-bandwidth mode is off
    a_r11_irq_needs_auto: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> auto_bw);

    // R3: reserved bits read as ones
    a_r3_reserved_ones: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hit |-> (bus_rdata[RSV_W-1:0] == RSV_VALUE));

    // R1: misses return zero
    a_r1_miss_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_hit |-> (bus_rdata == '0));

    // R10: flag hidden while automatic-bandwidth mode is off
    a_r10_flag_hidden: assert property (@(posedge clk) disable iff (!rst_n)
        !auto_bw |-> !bus_rdata[FLAG_BIT]);

endmodule

// File: tb/sim_clkctl_reg.sv
`timescale 1ns/1ps
module sim_clkctl_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_addr = 8'h00;
    logic       bus_rd = 1'b0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       lock_in = 1'b0;
    logic       auto_bw = 1'b1;
    logic       pll_on;
    logic       clk_sel;
    logic       irq;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } rd_item_t;

    rd_item_t sb_q[$];

    always #10 clk = ~clk;

    clkctl_reg u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_rd   (bus_rd),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .lock_in  (lock_in),
        .auto_bw  (auto_bw),
        .pll_on   (pll_on),
        .clk_sel  (clk_sel),
        .irq      (irq)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver: read with expected byte queued to the scoreboard
    task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
        bus_addr = addr;
        bus_rd   = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [7:0] addr, input logic [7:0] data);
        bus_addr  = addr;
        bus_wdata = data;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rmw(input logic [7:0] data, input logic [7:0] exp, input string tag);
        bus_addr  = 8'h1C;
        bus_wdata = data;
        bus_wr    = 1'b1;
        bus_rd    = 1'b1;
        sb_q.push_back('{exp: exp, tag: tag});
        @(negedge clk);
        bus_wr = 1'b0;
        bus_rd = 1'b0;
    endtask

    // Monitor: pops expected reads and compares
    initial begin
        forever begin
            @(negedge clk);
            #5;
            if (bus_rd) begin
                if (sb_q.size() == 0) begin
                    tests++;
                    fails++;
                    $display("FAIL scoreboard: unexpected read data %02h expected none", bus_rdata);
                end else begin
                    rd_item_t it;
                    it = sb_q.pop_front();
                    check(it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    initial begin
        #2000000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);

        // R2 reset state
        check("R2 pll_on", {7'd0, pll_on}, 8'h01);
        check("R2 clk_sel", {7'd0, clk_sel}, 8'h00);
        check("R2 irq", {7'd0, irq}, 8'h00);
        rd(8'h1C, 8'h2F, "R2 reset readback R3");

        // R1 decode
        rd(8'h1D, 8'h00, "R1 miss read");
        wr(8'h00, 8'h00);
        check("R1 miss write pll_on", {7'd0, pll_on}, 8'h01);
        rd(8'h1C, 8'h2F, "R1 after miss write");

        // R4 R5 R7: ie=1 pll=0 sel=1, flag and reserved write bits ignored
        wr(8'h1C, 8'hD0);
        check("R4 pll_on", {7'd0, pll_on}, 8'h00);
        check("R4 clk_sel", {7'd0, clk_sel}, 8'h01);
        rd(8'h1C, 8'h9F, "R7 write bits ignored R5");

        // R6 rising lock, timing
        lock_in = 1'b1;
        tick(2);
        check("R6 not before third edge", {7'd0, irq}, 8'h00);
        tick(1);
        check("R6 R11 irq after rise", {7'd0, irq}, 8'h01);
        rd(8'h1C, 8'hDF, "R6 flag after rise");
        check("R8 irq after read", {7'd0, irq}, 8'h00);
        rd(8'h1C, 8'h9F, "R8 flag cleared");

        // R6 falling lock
        lock_in = 1'b0;
        tick(3);
        rd(8'h1C, 8'hDF, "R6 flag after fall");
        rd(8'h1C, 8'h9F, "R8 cleared after fall");

        // R9 toggle coinciding with read while flag set
        lock_in = 1'b1;
        tick(3);
        lock_in = 1'b0;
        tick(2);
        rd(8'h1C, 8'hDF, "R9 coincident read");
        rd(8'h1C, 8'hDF, "R9 flag kept");
        rd(8'h1C, 8'h9F, "R9 cleared later");

        // R8 read-modify-write clears
        lock_in = 1'b1;
        tick(3);
        rmw(8'h90, 8'hDF, "R8 rmw read");
        rd(8'h1C, 8'h9F, "R8 rmw cleared");

        // R5 R10 R11 with automatic-bandwidth mode off
        auto_bw = 1'b0;
        tick(1);
        wr(8'h1C, 8'h00);
        rd(8'h1C, 8'h0F, "R5 ie hidden and frozen");
        lock_in = 1'b0;
        tick(3);
        check("R11 no irq when auto off", {7'd0, irq}, 8'h00);
        rd(8'h1C, 8'h0F, "R10 flag hidden");
        auto_bw = 1'b1;
        tick(1);
        rd(8'h1C, 8'h8F, "R5 ie retained");

        // R11 flag without enable
        wr(8'h1C, 8'h20);
        lock_in = 1'b1;
        tick(3);
        check("R11 no irq without enable", {7'd0, irq}, 8'h00);
        rd(8'h1C, 8'h6F, "R11 flag without enable");

        tick(2);
        check("scoreboard drained", 8'(sb_q.size()), 8'h00);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule